// File: doc/BRIEF.md
# Accumulator Machine Instruction-Cycle Sequencer

This block is the hardwired timing-step controller of a small 16-bit accumulator machine. A step counter advances once per clock. Each step drives a fixed set of control points into the datapath: the memory-address and memory-buffer mux selects, the load strobes of the address, buffer, instruction, program-counter, operand and accumulator registers, memory enable and write, program-counter increment, ALU function and shifter code. The first steps fetch an instruction and are the same for every opcode. The steps that follow are picked by combining the step number with a decode of the instruction's opcode. For the add instruction they fetch the operand addressed by the instruction's low 12 bits, add it to the accumulator and write the sum back. Any other opcode sends the counter straight back to step 1.

Every register load is a strobe that is raised in one step and dropped in the next. While memory is not ready, the memory-read step repeats with every output unchanged. All control outputs are registered. A parameter picks between the full 17-step sequence and a compressed 13-step sequence that merges compatible steps. In the compressed form, the address mux is left pointing at the program counter between instructions.

Top module: `instr_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), `step` is 0 and every control output is 0. The one exception is the compressed variant (COMPACT=1), where `mar_sel` is 01.
- R2: In the full variant, steps 1 to 7 fetch the instruction with `mar_sel`=01 (program counter). Step 2 raises `mar_load`. Steps 3 and 4 raise `mem_en` with `mem_we`=0 and `mbr_sel`=10 (memory), and step 4 also raises `mbr_load`. Step 5 raises `pc_inc` and `ir_load`. Step 6 raises `pc_inc` and `pc_load`. Step 7 drives nothing else.
- R3: When the opcode seen at step 6 is 0011, the full variant continues with steps 8 to 17 at `mar_sel`=00 (instruction low bits). Step 9 raises `mar_load`. Steps 10 and 11 raise `mem_en` with `mbr_sel`=10, and step 11 also raises `mbr_load`. Step 13 raises `tmp_load`. Steps 14 to 16 drive `alu_fn`=101 (add) with `shift_op`=00 and `acc_sel`=00. Step 16 raises `acc_load`. Step 17 drives nothing else.
- R4: Any other opcode sends the counter from the last fetch step to step 1: from step 7 in the full variant, and from step 6 in the compressed variant. In the compressed variant, step 6 then keeps `mar_sel` at 01.
- R5: While `mem_ready` is low in a memory-wait step, the step number and every control output stay unchanged. These steps are 3 and 10 in the full variant, and 2 and 8 in the compressed one.
- R6: Each load strobe is high for exactly one step of a sequence. At most one load strobe is high in any step.
- R7: After the last step of an add (17, or 13 when compressed), the counter returns to step 1.
- R8: The compressed variant runs these 13 steps. Step 1 raises `mar_load` at `mar_sel`=01. Steps 2 and 3 read memory, with `mbr_load` in step 3. Step 4 raises `pc_inc` and `ir_load`, and step 5 raises `pc_inc` and `pc_load`. Step 6 sets `mar_sel`=00 for an add. Step 7 raises `mar_load`. Steps 8 and 9 read memory, with `mbr_load` in step 9. Step 10 raises `tmp_load`. Steps 11 and 12 drive `alu_fn`=101, and step 12 raises `acc_load`. Step 13 returns `mar_sel` to 01.
- R9: The opcode is sampled only when leaving the decode step (step 6 full, step 5 compressed). A change of `ir_op` after that point does not alter the path taken.
- R10: `step` shows the current step number, from 1 up to the variant's last step, and it changes on the same edge as the control outputs of that step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_op | input | 4 | Top four bits of the instruction register |
| mem_ready | input | 1 | Memory data word available |
| mar_sel | output | 2 | Address mux select: 01 program counter, 00 instruction low 12 bits |
| mar_load | output | 1 | Address register load strobe |
| mem_en | output | 1 | Memory enable |
| mem_we | output | 1 | Memory write (0 = read) |
| mbr_sel | output | 2 | Buffer mux select: 10 memory |
| mbr_load | output | 1 | Buffer register load strobe |
| pc_inc | output | 1 | Program-counter increment enable |
| ir_load | output | 1 | Instruction register load strobe |
| pc_load | output | 1 | Program-counter load strobe |
| tmp_load | output | 1 | Operand register load strobe |
| alu_fn | output | 3 | ALU function: 101 add |
| shift_op | output | 2 | Shifter code: 00 pass-through |
| acc_sel | output | 2 | Accumulator mux select: 00 shifter |
| acc_load | output | 1 | Accumulator load strobe |
| step | output | STEP_W | Current timing step |

## Verification
The hard cases to reach are a memory stall that falls in the middle of an instruction, and an opcode that changes after it has been decoded. Neither happens if the inputs are left at their idle values. The stimulus lowers `mem_ready` one step before the counter reaches a memory-wait step, holds it there for several clocks, then checks that the step number and the full control word stay frozen before the read completes. For the decode case, the stimulus presents the add opcode during the decode step, swaps to another opcode on the next step, and checks that the operand fetch still begins. Both variants run side by side, so the compressed sequence and its different wait and branch steps are covered by the same pass.

// File: rtl/instr_seq_pkg.sv
// Package: shared control-word type and field encodings for the sequencer.
// Assumes the datapath decodes the select codes exactly as listed here.
package instr_seq_pkg;

    localparam logic [1:0] MAR_SEL_IR  = 2'b00;
    localparam logic [1:0] MAR_SEL_PC  = 2'b01;
    localparam logic [1:0] MBR_SEL_MEM = 2'b10;
    localparam logic [2:0] ALU_ADD     = 3'b101;
    localparam logic [1:0] SHF_PASS    = 2'b00;
    localparam logic [1:0] ACC_SEL_SHF = 2'b00;

    typedef struct packed {
        logic [1:0] mar_sel;
        logic       mar_ld;
        logic       mem_en;
        logic       mem_we;
        logic [1:0] mbr_sel;
        logic       mbr_ld;
        logic       pc_inc;
        logic       ir_ld;
        logic       pc_ld;
        logic       tmp_ld;
        logic [2:0] alu_fn;
        logic [1:0] shf;
        logic [1:0] acc_sel;
        logic       acc_ld;
    } ctl_word_t;

endpackage

// File: rtl/instr_seq_opdec.sv
// Opcode match: flags the add opcode in the top bits of the instruction.
// Assumes ir_op is already the opcode field; no other opcodes are decoded.
module instr_seq_opdec #(
    parameter int          OP_W   = 4,
    parameter logic [OP_W-1:0] ADD_OP = 4'b0011
) (
    input  logic [OP_W-1:0] ir_op,
    output logic            is_add
);

    // compare against the add opcode
    always_comb begin
        is_add = (ir_op == ADD_OP);
    end

endmodule

// File: rtl/instr_seq_stepper.sv
// Step counter: advances one step per clock, holds in memory-wait steps
// while memory is not ready, branches on the latched decode, and wraps.
// Assumes step 0 exists only after reset. Synchronous active-low reset.
module instr_seq_stepper #(
    parameter int STEP_W  = 5,
    parameter int COMPACT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_add,
    input  logic              mem_rdy,
    output logic [STEP_W-1:0] step_q,
    output logic [STEP_W-1:0] step_nxt,
    output logic              add_nxt
);

    localparam int LAST   = (COMPACT != 0) ? 13 : 17;
    localparam int BRANCH = (COMPACT != 0) ? 6 : 7;
    localparam int DECODE = BRANCH - 1;
    localparam int MEM_A  = (COMPACT != 0) ? 2 : 3;
    localparam int MEM_B  = (COMPACT != 0) ? 8 : 10;

    logic add_q;
    int   cur;
    int   nxt;

    // choose the following step and the decode flag that goes with it
    always_comb begin
        cur     = int'(step_q);
        add_nxt = (cur == DECODE) ? is_add : add_q;
        if (cur == 0)
            nxt = 1;
        else if ((cur == MEM_A || cur == MEM_B) && !mem_rdy)
            nxt = cur;
        else if (cur == BRANCH && !add_q)
            nxt = 1;
        else if (cur == LAST)
            nxt = 1;
        else
            nxt = cur + 1;
        step_nxt = STEP_W'(nxt);
    end

    // step and decode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            add_q  <= 1'b0;
        end else begin
            step_q <= step_nxt;
            add_q  <= add_nxt;
        end
    end

    AST_WAIT_HOLDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(step_q) == MEM_A || int'(step_q) == MEM_B) && !mem_rdy) |=> $stable(step_q)); // R5
    AST_NON_ADD_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(step_q) == BRANCH && !add_q) |=> (int'(step_q) == 1)); // R4
    AST_WRAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(step_q) == LAST) |=> (int'(step_q) == 1)); // R7
    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(step_q) >= 1 && int'(step_q) <= LAST)); // R10

endmodule

// File: rtl/instr_seq_ctlgen.sv
// Control-word generator: maps a step number and the add decode to the
// full set of control points. The variant is picked by COMPACT.
// Assumes fields not named in a step are zero.
module instr_seq_ctlgen
    import instr_seq_pkg::*;
#(
    parameter int STEP_W  = 5,
    parameter int COMPACT = 0
) (
    input  logic [STEP_W-1:0] step,
    input  logic              is_add,
    output ctl_word_t         word
);

    int s;

    generate
        if (COMPACT != 0) begin : g_compact
            // merged 13-step sequence
            always_comb begin
                s    = int'(step);
                word = '0;
                word.mar_sel = (s <= 5 || s == 13 || (s == 6 && !is_add)) ? MAR_SEL_PC : MAR_SEL_IR;
                word.mar_ld  = (s == 1 || s == 7);
                word.mem_en  = (s == 2 || s == 3 || s == 8 || s == 9);
                word.mbr_sel = word.mem_en ? MBR_SEL_MEM : 2'b00;
                word.mbr_ld  = (s == 3 || s == 9);
                word.pc_inc  = (s == 4 || s == 5);
                word.ir_ld   = (s == 4);
                word.pc_ld   = (s == 5);
                word.tmp_ld  = (s == 10);
                word.alu_fn  = (s == 11 || s == 12) ? ALU_ADD : 3'b000;
                word.shf     = SHF_PASS;
                word.acc_sel = ACC_SEL_SHF;
                word.acc_ld  = (s == 12);
            end
        end else begin : g_full
            // one control change per step, 17 steps
            always_comb begin
                s    = int'(step);
                word = '0;
                word.mar_sel = (s <= 7) ? MAR_SEL_PC : MAR_SEL_IR;
                word.mar_ld  = (s == 2 || s == 9);
                word.mem_en  = (s == 3 || s == 4 || s == 10 || s == 11);
                word.mbr_sel = word.mem_en ? MBR_SEL_MEM : 2'b00;
                word.mbr_ld  = (s == 4 || s == 11);
                word.pc_inc  = (s == 5 || s == 6);
                word.ir_ld   = (s == 5);
                word.pc_ld   = (s == 6);
                word.tmp_ld  = (s == 13);
                word.alu_fn  = (s >= 14 && s <= 16) ? ALU_ADD : 3'b000;
                word.shf     = SHF_PASS;
                word.acc_sel = ACC_SEL_SHF;
                word.acc_ld  = (s == 16);
            end
        end
    endgenerate

endmodule

// File: rtl/instr_seq.sv
// Instruction-cycle sequencer top: registers the control word of the next
// step so every control point changes on the clock edge with the step number.
// Assumes ir_op is valid by the decode step. Synchronous active-low reset.
module instr_seq
    import instr_seq_pkg::*;
#(
    parameter int          STEP_W  = 5,
    parameter int          OP_W    = 4,
    parameter logic [OP_W-1:0] ADD_OP  = 4'b0011,
    parameter int          COMPACT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   ir_op,
    input  logic              mem_ready,
    output logic [1:0]        mar_sel,
    output logic              mar_load,
    output logic              mem_en,
    output logic              mem_we,
    output logic [1:0]        mbr_sel,
    output logic              mbr_load,
    output logic              pc_inc,
    output logic              ir_load,
    output logic              pc_load,
    output logic              tmp_load,
    output logic [2:0]        alu_fn,
    output logic [1:0]        shift_op,
    output logic [1:0]        acc_sel,
    output logic              acc_load,
    output logic [STEP_W-1:0] step
);

    localparam ctl_word_t RST_WORD = '{
        mar_sel: ((COMPACT != 0) ? MAR_SEL_PC : MAR_SEL_IR),
        default: '0
    };

    logic              is_add;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] step_nxt;
    logic              add_nxt;
    ctl_word_t         word_nxt;
    ctl_word_t         ctl_q;

    instr_seq_opdec #(.OP_W(OP_W), .ADD_OP(ADD_OP)) u_opdec (
        .ir_op  (ir_op),
        .is_add (is_add)
    );

    instr_seq_stepper #(.STEP_W(STEP_W), .COMPACT(COMPACT)) u_stepper (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_add   (is_add),
        .mem_rdy  (mem_ready),
        .step_q   (step_q),
        .step_nxt (step_nxt),
        .add_nxt  (add_nxt)
    );

    instr_seq_ctlgen #(.STEP_W(STEP_W), .COMPACT(COMPACT)) u_ctlgen (
        .step   (step_nxt),
        .is_add (add_nxt),
        .word   (word_nxt)
    );

    // control-word register, loaded with the word of the step being entered
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= RST_WORD;
        else        ctl_q <= word_nxt;
    end

    // fan the register out to the control points
    always_comb begin
        mar_sel  = ctl_q.mar_sel;
        mar_load = ctl_q.mar_ld;
        mem_en   = ctl_q.mem_en;
        mem_we   = ctl_q.mem_we;
        mbr_sel  = ctl_q.mbr_sel;
        mbr_load = ctl_q.mbr_ld;
        pc_inc   = ctl_q.pc_inc;
        ir_load  = ctl_q.ir_ld;
        pc_load  = ctl_q.pc_ld;
        tmp_load = ctl_q.tmp_ld;
        alu_fn   = ctl_q.alu_fn;
        shift_op = ctl_q.shf;
        acc_sel  = ctl_q.acc_sel;
        acc_load = ctl_q.acc_ld;
        step     = step_q;
    end

    AST_WAIT_FREEZES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mem_en && !ctl_q.mbr_ld && !mem_ready) |=> $stable(ctl_q)); // R5
    AST_ONE_LOAD_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_q.mar_ld, ctl_q.mbr_ld, ctl_q.ir_ld, ctl_q.pc_ld, ctl_q.tmp_ld, ctl_q.acc_ld})); // R6
    AST_MAR_STROBE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.mar_ld |=> !ctl_q.mar_ld); // R6
    AST_MBR_STROBE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.mbr_ld |=> !ctl_q.mbr_ld); // R6
    AST_ACC_STROBE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.acc_ld |=> !ctl_q.acc_ld); // R6
    AST_PC_LOAD_WITH_INC: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.pc_ld |-> ctl_q.pc_inc); // R2
    AST_MEM_READS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.mem_en |-> (!ctl_q.mem_we && ctl_q.mbr_sel == MBR_SEL_MEM)); // R2
    AST_ACC_LOAD_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.acc_ld |-> (ctl_q.alu_fn == ALU_ADD && $past(ctl_q.alu_fn) == ALU_ADD)); // R3

endmodule

// File: tb/instr_seq_tb.sv
// Bench: runs the full and compressed sequencers side by side. A vector
// table per variant is walked by one loop, then directed tests follow.
module instr_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_l = 4'b0011;
    logic [3:0] op_c = 4'b0011;
    logic       rdy_l = 1'b1;
    logic       rdy_c = 1'b1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    logic [1:0] ms_l, bs_l, hs_l, as_l, ms_c, bs_c, hs_c, as_c;
    logic [2:0] af_l, af_c;
    logic [4:0] st_l, st_c;
    logic ml_l, me_l, mw_l, bl_l, pi_l, il_l, pl_l, tl_l, al_l;
    logic ml_c, me_c, mw_c, bl_c, pi_c, il_c, pl_c, tl_c, al_c;

    instr_seq #(.COMPACT(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .ir_op(op_l), .mem_ready(rdy_l),
        .mar_sel(ms_l), .mar_load(ml_l), .mem_en(me_l), .mem_we(mw_l),
        .mbr_sel(bs_l), .mbr_load(bl_l), .pc_inc(pi_l), .ir_load(il_l),
        .pc_load(pl_l), .tmp_load(tl_l), .alu_fn(af_l), .shift_op(hs_l),
        .acc_sel(as_l), .acc_load(al_l), .step(st_l)
    );

    instr_seq #(.COMPACT(1)) u_dut_cmp (
        .clk(clk), .rst_n(rst_n), .ir_op(op_c), .mem_ready(rdy_c),
        .mar_sel(ms_c), .mar_load(ml_c), .mem_en(me_c), .mem_we(mw_c),
        .mbr_sel(bs_c), .mbr_load(bl_c), .pc_inc(pi_c), .ir_load(il_c),
        .pc_load(pl_c), .tmp_load(tl_c), .alu_fn(af_c), .shift_op(hs_c),
        .acc_sel(as_c), .acc_load(al_c), .step(st_c)
    );

    // layout: mar_sel, mar_load, mem_en, mem_we, mbr_sel, mbr_load, pc_inc,
    // ir_load, pc_load, tmp_load, alu_fn, shift_op, acc_sel, acc_load
    wire [19:0] w_l = {ms_l, ml_l, me_l, mw_l, bs_l, bl_l, pi_l, il_l, pl_l, tl_l, af_l, hs_l, as_l, al_l};
    wire [19:0] w_c = {ms_c, ml_c, me_c, mw_c, bs_c, bl_c, pi_c, il_c, pl_c, tl_c, af_c, hs_c, as_c, al_c};

    localparam logic [19:0] LD_MASK = 20'b00_1_0_0_00_1_0_1_1_1_000_00_00_1;

    localparam logic [19:0] TAB_L [17] = '{
        20'b01_0_0_0_00_0_0_0_0_0_000_00_00_0,
        20'b01_1_0_0_00_0_0_0_0_0_000_00_00_0,
        20'b01_0_1_0_10_0_0_0_0_0_000_00_00_0,
        20'b01_0_1_0_10_1_0_0_0_0_000_00_00_0,
        20'b01_0_0_0_00_0_1_1_0_0_000_00_00_0,
        20'b01_0_0_0_00_0_1_0_1_0_000_00_00_0,
        20'b01_0_0_0_00_0_0_0_0_0_000_00_00_0,
        20'b00_0_0_0_00_0_0_0_0_0_000_00_00_0,
        20'b00_1_0_0_00_0_0_0_0_0_000_00_00_0,
        20'b00_0_1_0_10_0_0_0_0_0_000_00_00_0,
        20'b00_0_1_0_10_1_0_0_0_0_000_00_00_0,
        20'b00_0_0_0_00_0_0_0_0_0_000_00_00_0,
        20'b00_0_0_0_00_0_0_0_0_1_000_00_00_0,
        20'b00_0_0_0_00_0_0_0_0_0_101_00_00_0,
        20'b00_0_0_0_00_0_0_0_0_0_101_00_00_0,
        20'b00_0_0_0_00_0_0_0_0_0_101_00_00_1,
        20'b00_0_0_0_00_0_0_0_0_0_000_00_00_0
    };

    localparam logic [19:0] TAB_C [13] = '{
        20'b01_1_0_0_00_0_0_0_0_0_000_00_00_0,
        20'b01_0_1_0_10_0_0_0_0_0_000_00_00_0,
        20'b01_0_1_0_10_1_0_0_0_0_000_00_00_0,
        20'b01_0_0_0_00_0_1_1_0_0_000_00_00_0,
        20'b01_0_0_0_00_0_1_0_1_0_000_00_00_0,
        20'b00_0_0_0_00_0_0_0_0_0_000_00_00_0,
        20'b00_1_0_0_00_0_0_0_0_0_000_00_00_0,
        20'b00_0_1_0_10_0_0_0_0_0_000_00_00_0,
        20'b00_0_1_0_10_1_0_0_0_0_000_00_00_0,
        20'b00_0_0_0_00_0_0_0_0_1_000_00_00_0,
        20'b00_0_0_0_00_0_0_0_0_0_101_00_00_0,
        20'b00_0_0_0_00_0_0_0_0_0_101_00_00_1,
        20'b01_0_0_0_00_0_0_0_0_0_000_00_00_0
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [19:0] prev_l;
        logic [19:0] prev_c;
        bit          long_run;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(st_l == 5'd0 && w_l == 20'h0, "R1 full reset", {st_l, w_l}, 32'h0);
        chk(st_c == 5'd0 && w_c == 20'h40000, "R1 compressed reset", {st_c, w_c}, {5'd0, 20'h40000});

        // walk both tables with an add opcode and memory always ready
        rst_n    = 1'b1;
        prev_l   = '0;
        prev_c   = '0;
        long_run = 1'b0;
        for (int i = 0; i < 17; i++) begin
            tick();
            chk(w_l == TAB_L[i], (i < 7) ? "R2 fetch word" : "R3 add word", w_l, TAB_L[i]);
            chk(st_l == 5'(i + 1), "R10 full step", st_l, i + 1);
            if ((w_l & prev_l & LD_MASK) != 0) long_run = 1'b1;
            prev_l = w_l;
            if (i < 13) begin
                chk(w_c == TAB_C[i], "R8 compressed word", w_c, TAB_C[i]);
                chk(st_c == 5'(i + 1), "R10 compressed step", st_c, i + 1);
                if ((w_c & prev_c & LD_MASK) != 0) long_run = 1'b1;
                prev_c = w_c;
            end
        end
        chk(!long_run, "R6 strobe longer than one step", long_run, 0);

        // R7: wrap after the last add step
        tick();
        chk(st_l == 5'd1 && w_l == TAB_L[0], "R7 wrap to step 1", st_l, 1);

        // R5: memory wait in the fetch read
        tick();
        rdy_l = 1'b0;
        tick();
        chk(st_l == 5'd3 && w_l == TAB_L[2], "R5 enter wait step", {st_l, w_l}, {5'd3, TAB_L[2]});
        tick();
        tick();
        chk(st_l == 5'd3 && w_l == TAB_L[2], "R5 held while not ready", {st_l, w_l}, {5'd3, TAB_L[2]});
        rdy_l = 1'b1;
        tick();
        chk(st_l == 5'd4 && w_l == TAB_L[3], "R5 resume after ready", {st_l, w_l}, {5'd4, TAB_L[3]});

        // R4: non-add opcode returns to fetch after step 7
        tick();
        tick();
        op_l = 4'b0101;
        tick();
        chk(st_l == 5'd7, "R4 reach step 7", st_l, 7);
        tick();
        chk(st_l == 5'd1 && w_l == TAB_L[0], "R4 non-add back to step 1", st_l, 1);

        // R9: opcode change after decode has no effect
        op_l = 4'b0011;
        repeat (5) tick();
        chk(st_l == 5'd6, "R9 reach decode step", st_l, 6);
        tick();
        op_l = 4'b0000;
        tick();
        chk(st_l == 5'd8 && w_l == TAB_L[7], "R9 add path kept", st_l, 8);

        // R1: reset from a running state; then compressed wait and non-add
        rst_n = 1'b0;
        op_c  = 4'b0101;
        rdy_c = 1'b0;
        tick();
        chk(st_l == 5'd0 && w_l == 20'h0, "R1 full reset while running", {st_l, w_l}, 32'h0);
        chk(st_c == 5'd0 && w_c == 20'h40000, "R1 compressed reset while running", {st_c, w_c}, {5'd0, 20'h40000});
        rst_n = 1'b1;
        tick();
        tick();
        tick();
        chk(st_c == 5'd2 && w_c == TAB_C[1], "R5 compressed wait held", {st_c, w_c}, {5'd2, TAB_C[1]});
        rdy_c = 1'b1;
        repeat (4) tick();
        chk(st_c == 5'd6 && w_c == 20'h40000, "R4 compressed non-add step 6 keeps mux", {st_c, w_c}, {5'd6, 20'h40000});
        tick();
        chk(st_c == 5'd1 && w_c == TAB_C[0], "R4 compressed back to step 1", st_c, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule